// File: doc/BRIEF.md
# Chained Converter Burst Reader

This block is a host-side serial master for a chain of one or more analog-to-digital converters. The converters share one serial data line into the host. A free-running timer requests a conversion at a fixed cycle period. The converters report the end of each conversion by dropping their busy line, and that falling edge launches one read burst. The block drives the active-low chip select and the serial clock for the burst and collects the result of every device in the chain.

The serial clock rests low. Each data bit is captured on the falling half of its clock pulse. The burst is made of 8-bit groups, and a longer low pause can separate two groups. Chip select stays low from the first group to the last. Each finished 16-bit word leaves the block with a one-cycle strobe and the position of its device in the chain. Device 0 is the device whose output reaches the host directly, and its word arrives first.

A conversion request that expires while a burst is running is held back. The convert pulse then goes out once chip select has returned high.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is high and on the first cycle after it, cs_n_o is 1 and sclk_o, cnv_o and word_valid_o are 0.
- R2: The timer expires every CONV_PERIOD cycles after reset, first on the CONV_PERIOD-th rising edge after reset is released. When no burst is running, cnv_o is high for exactly the one cycle after the cycle that follows that expiry.
- R3: A timer expiry while cs_n_o is low keeps the request pending. cnv_o is never high while a burst runs. It pulses on the cycle after the first cycle in which cs_n_o is seen high again.
- R4: A burst starts only when busy_i is sampled 1 on one edge and 0 on the next while no burst is running. cs_n_o falls on that second edge. A busy_i that stays low starts nothing further, and a falling edge during a burst is ignored.
- R5: cs_n_o stays low for the whole burst. It returns high CLK_DIV cycles after the last falling edge of sclk_o.
- R6: sclk_o is 0 whenever cs_n_o is 1. The first rising edge comes CLK_DIV cycles after cs_n_o falls. Every high phase lasts CLK_DIV cycles, and so does every low phase inside an 8-bit group.
- R7: sdo_i is captured on the cycle in which sclk_o falls. Each 16-bit word is assembled with the most significant bit first.
- R8: The low phase that comes before the first bit of each 8-bit group after the first lasts BYTE_GAP cycles instead of CLK_DIV.
- R9: One burst has exactly 16*N_DEV clock pulses and yields N_DEV words. Their indices are 0, 1, ... N_DEV-1 in arrival order.
- R10: word_valid_o is high for one cycle. That cycle is the one in which sclk_o falls for the 16th bit of a word, and word_data_o and word_idx_o are valid in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | End-of-conversion line from the chain, high while converting |
| sdo_i | input | 1 | Serial data from the device nearest the host |
| cnv_o | output | 1 | One-cycle convert-start pulse |
| cs_n_o | output | 1 | Active-low chip select, low for a whole burst |
| sclk_o | output | 1 | Serial clock, idles low |
| word_valid_o | output | 1 | Strobe for a finished word |
| word_data_o | output | 16 | Finished word, most significant bit first on the wire |
| word_idx_o | output | max(1,clog2(N_DEV)) | Chain position of the finished word |

## Verification
Two functions can fall in the same cycle here. The conversion timer may expire while a read burst still holds chip select low, and the busy line may fall while a burst is already running. The bench sets the timer period shorter than a conversion plus a burst, so nearly every request lands inside a burst. It also injects a short busy pulse into the middle of one burst. A behavioural model works out convert pulses, chip select, clock phases and words from closed-form timing, and the outputs are compared with it on every cycle.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

    localparam int WORD_BITS = 16;
    localparam int GROUP_BITS = 8;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_LEAD,
        RD_HIGH,
        RD_LOW,
        RD_TAIL
    } rd_state_e;

    typedef struct packed {
        logic                 valid;
        logic [WORD_BITS-1:0] data;
    } word_out_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic group_edge(input int unsigned n);
        return (n != 0) && ((n % GROUP_BITS) == 0);
    endfunction

    function automatic logic word_last_bit(input int unsigned n);
        return (n % WORD_BITS) == (WORD_BITS - 1);
    endfunction

endpackage

// File: rtl/cnv_timer.sv
module cnv_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_active_i,
    output logic cnv_o
);
    localparam int TCW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [TCW-1:0] cnt_q;
    logic           pend_q;
    logic           expire;

    assign expire = (cnt_q == TCW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            cnv_o  <= 1'b0;
        end else begin
            cnt_q  <= expire ? '0 : cnt_q + 1'b1;
            cnv_o  <= pend_q & ~burst_active_i;
            pend_q <= expire | (pend_q & burst_active_i);
        end
    end

    // R3
    cnv_outside_burst_chk: assert property (@(posedge clk) disable iff (rst)
        cnv_o |-> $past(!burst_active_i));

endmodule

// File: rtl/busy_fall_det.sv
module busy_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    output logic fall_o
);
    logic busy_d;

    always_ff @(posedge clk) begin
        if (rst) busy_d <= 1'b0;
        else     busy_d <= busy_i;
    end

    assign fall_o = busy_d & ~busy_i;

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
    import rdr_pkg::*;
#(
    parameter int N_DEV    = 3,
    parameter int CLK_DIV  = 4,
    parameter int BYTE_GAP = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      sdo_i,
    output logic                      cs_n_o,
    output logic                      sclk_o,
    output word_out_t                 word_o,
    output logic [idx_w(N_DEV)-1:0]   idx_o
);
    localparam int TOT  = WORD_BITS * N_DEV;
    localparam int BCW  = $clog2(TOT + 1);
    localparam int WMAX = (CLK_DIV > BYTE_GAP) ? CLK_DIV : BYTE_GAP;
    localparam int WCW  = $clog2(WMAX + 1);
    localparam int IW   = idx_w(N_DEV);

    rd_state_e            state_q;
    logic [WCW-1:0]       wcnt_q;
    logic [BCW-1:0]       bit_q;
    logic [WORD_BITS-2:0] sh_q;
    logic [WORD_BITS-1:0] nxt_word;
    logic [WCW-1:0]       low_lim;
    logic                 div_done;

    assign nxt_word = {sh_q, sdo_i};
    assign div_done = (wcnt_q == WCW'(CLK_DIV - 1));
    assign low_lim  = group_edge(32'(bit_q)) ? WCW'(BYTE_GAP - 1) : WCW'(CLK_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            cs_n_o  <= 1'b1;
            sclk_o  <= 1'b0;
            wcnt_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            word_o  <= '0;
            idx_o   <= '0;
        end else begin
            word_o.valid <= 1'b0;
            unique case (state_q)
                RD_IDLE: begin
                    if (start_i) begin
                        state_q <= RD_LEAD;
                        cs_n_o  <= 1'b0;
                        wcnt_q  <= '0;
                        bit_q   <= '0;
                    end
                end
                RD_LEAD: begin
                    if (div_done) begin
                        wcnt_q  <= '0;
                        sclk_o  <= 1'b1;
                        state_q <= RD_HIGH;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                RD_HIGH: begin
                    if (div_done) begin
                        wcnt_q <= '0;
                        sclk_o <= 1'b0;
                        sh_q   <= nxt_word[WORD_BITS-2:0];
                        bit_q  <= bit_q + 1'b1;
                        if (word_last_bit(32'(bit_q))) begin
                            word_o.valid <= 1'b1;
                            word_o.data  <= nxt_word;
                            idx_o        <= IW'(bit_q >> 4);
                        end
                        state_q <= (bit_q == BCW'(TOT - 1)) ? RD_TAIL : RD_LOW;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                RD_LOW: begin
                    if (wcnt_q == low_lim) begin
                        wcnt_q  <= '0;
                        sclk_o  <= 1'b1;
                        state_q <= RD_HIGH;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                RD_TAIL: begin
                    if (div_done) begin
                        wcnt_q  <= '0;
                        cs_n_o  <= 1'b1;
                        state_q <= RD_IDLE;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    // R6
    sclk_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !cs_n_o);

    // R10
    valid_on_sclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
        word_o.valid |-> $fell(sclk_o));

    // R4
    select_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> $past(start_i));

endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
    import rdr_pkg::*;
#(
    parameter int N_DEV       = 3,
    parameter int CLK_DIV     = 4,
    parameter int BYTE_GAP    = 6,
    parameter int CONV_PERIOD = 1000
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            busy_i,
    input  logic                            sdo_i,
    output logic                            cnv_o,
    output logic                            cs_n_o,
    output logic                            sclk_o,
    output logic                            word_valid_o,
    output logic [WORD_BITS-1:0]            word_data_o,
    output logic [idx_w(N_DEV)-1:0]         word_idx_o
);
    logic      busy_fall;
    word_out_t word_s;

    busy_fall_det u_fall (
        .clk    (clk),
        .rst    (rst),
        .busy_i (busy_i),
        .fall_o (busy_fall)
    );

    cnv_timer #(.PERIOD(CONV_PERIOD)) u_timer (
        .clk            (clk),
        .rst            (rst),
        .burst_active_i (~cs_n_o),
        .cnv_o          (cnv_o)
    );

    serial_rx_engine #(
        .N_DEV    (N_DEV),
        .CLK_DIV  (CLK_DIV),
        .BYTE_GAP (BYTE_GAP)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start_i (busy_fall),
        .sdo_i   (sdo_i),
        .cs_n_o  (cs_n_o),
        .sclk_o  (sclk_o),
        .word_o  (word_s),
        .idx_o   (word_idx_o)
    );

    assign word_valid_o = word_s.valid;
    assign word_data_o  = word_s.data;

    // R5
    word_inside_burst_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> !cs_n_o);

endmodule

// File: tb/chain_adc_reader_tb.sv
module chain_adc_reader_tb_top;
    localparam int CLK_T  = 10;
    localparam int N      = 2;
    localparam int D      = 2;
    localparam int G      = 3;
    localparam int P      = 120;
    localparam int CONV   = 10;
    localparam int TOT    = 16 * N;
    localparam int RUN    = 1500;
    localparam int IW     = rdr_pkg::idx_w(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic busy_i = 1'b0;
    logic sdo_i = 1'b0;
    logic cnv_o, cs_n_o, sclk_o, word_valid_o;
    logic [15:0]   word_data_o;
    logic [IW-1:0] word_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    int words_seen = 0;
    bit done = 0;

    always #(CLK_T/2) clk = ~clk;

    chain_adc_reader #(
        .N_DEV(N), .CLK_DIV(D), .BYTE_GAP(G), .CONV_PERIOD(P)
    ) dut_i (
        .clk(clk), .rst(rst), .busy_i(busy_i), .sdo_i(sdo_i),
        .cnv_o(cnv_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .word_valid_o(word_valid_o), .word_data_o(word_data_o),
        .word_idx_o(word_idx_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    function automatic int rise_at(input int b);
        return D + 2 * D * b + (b / 8) * (G - D);
    endfunction

    function automatic bit sclk_at(input int k);
        for (int b = 0; b < TOT; b++)
            if (k >= rise_at(b) && k < rise_at(b) + D) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int fall_bit(input int k);
        for (int b = 0; b < TOT; b++)
            if (k == rise_at(b) + D) return b;
        return -1;
    endfunction

    function automatic bit in_gap(input int k);
        for (int b = 7; b < TOT - 1; b += 8)
            if (k >= rise_at(b) + D && k < rise_at(b + 1)) return 1'b1;
        return 1'b0;
    endfunction

    localparam int BURST_END = rise_at(TOT - 1) + 2 * D;

    // chain contents offered by the converter model, index 0 arrives first
    logic [15:0] chain_w [N];
    logic [15:0] model_w [N];

    // reference model state
    int tcnt = 0;
    bit pend = 0, def_flag = 0, e_cnv = 0, e_cnv_def = 0, e_cs = 1, busy_prev = 0;
    int rel = 0;

    always @(posedge clk) begin
        if (rst) begin
            tcnt = 0; pend = 0; def_flag = 0; e_cnv = 0; e_cnv_def = 0;
            e_cs = 1; busy_prev = 0; rel = 0;
        end else begin
            bit cs_pre, tick;
            cs_pre = e_cs;
            tick = (tcnt == P - 1);
            tcnt = tick ? 0 : tcnt + 1;
            e_cnv = pend && cs_pre;
            e_cnv_def = e_cnv && def_flag;
            if (e_cnv) def_flag = 0;
            if (pend && !cs_pre) def_flag = 1;
            pend = tick || (pend && !cs_pre);
            if (!cs_pre) begin
                rel++;
                if (rel == BURST_END) e_cs = 1;
            end else if (busy_prev && !busy_i) begin
                e_cs = 0;
                rel = 0;
                for (int d = 0; d < N; d++) model_w[d] = chain_w[d];
            end
            busy_prev = busy_i;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_sclk, e_val;
            int fb;
            e_sclk = !e_cs && sclk_at(rel);
            fb = e_cs ? -1 : fall_bit(rel);
            e_val = (fb >= 0) && (fb % 16 == 15);
            chk(cnv_o == e_cnv, e_cnv_def ? "R3" : "R2", cnv_o, e_cnv);
            chk(cs_n_o == e_cs, e_cs ? "R4" : "R5", cs_n_o, e_cs);
            chk(sclk_o == e_sclk, (!e_cs && in_gap(rel)) ? "R8" : "R6", sclk_o, e_sclk);
            chk(word_valid_o == e_val, "R10", word_valid_o, e_val);
            if (e_val && word_valid_o) begin
                words_seen++;
                chk(word_data_o == model_w[fb / 16], "R7", word_data_o, model_w[fb / 16]);
                chk(int'(word_idx_o) == fb / 16, "R9", word_idx_o, fb / 16);
            end
        end
    end

    // converter chain model and stimulus
    int conv_left = 0, spur_left = 0, bursts = 0, in_burst = 0, ptr = 0;
    bit sclk_seen = 0, cs_seen = 1;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] pick_word(input int k, input int d);
        case (k % 4)
            0: return d[0] ? 16'hFFFF : 16'h0000;
            1: return d[0] ? 16'h5555 : 16'hAAAA;
            2: return d[0] ? 16'h7FFE : 16'h8001;
            default: return lfsr ^ 16'(d * 16'h1357);
        endcase
    endfunction

    initial begin
        for (int d = 0; d < N; d++) begin chain_w[d] = 16'h0; model_w[d] = 16'h0; end
        repeat (3) @(posedge clk);
        #1;
        // R1 while reset is high
        chk(cs_n_o == 1'b1 && sclk_o == 1'b0 && cnv_o == 1'b0 && word_valid_o == 1'b0,
            "R1", {cs_n_o, sclk_o, cnv_o, word_valid_o}, 4'b1000);
        rst = 1'b0;
        for (int cyc = 0; cyc < RUN; cyc++) begin
            @(posedge clk);
            #1;
            if (cyc == 0)
                chk(cs_n_o == 1'b1 && sclk_o == 1'b0 && cnv_o == 1'b0,
                    "R1", {cs_n_o, sclk_o, cnv_o}, 3'b100);
            if (conv_left > 0) conv_left--;
            if (spur_left > 0) spur_left--;
            if (cnv_o) begin
                conv_left = CONV;
                for (int d = 0; d < N; d++) chain_w[d] = pick_word(bursts, d);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                ptr = 0;
            end
            if (cs_seen && !cs_n_o) begin bursts++; in_burst = 0; end
            if (!cs_n_o) in_burst++;
            // R4: stray busy pulse in the middle of the second burst
            if (bursts == 2 && in_burst == 50) spur_left = 2;
            busy_i = (conv_left > 0) || (spur_left > 0);
            if (sclk_o && !sclk_seen) begin
                sdo_i = (ptr < TOT) ? chain_w[ptr / 16][15 - (ptr % 16)] : 1'b0;
                ptr++;
            end
            sclk_seen = sclk_o;
            cs_seen = cs_n_o;
        end
        done = 1;
        // R9: complete bursts delivered every word
        chk(words_seen >= 4 * N && words_seen % N == 0, "R9", words_seen, 4 * N);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_T * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule